// File: doc/BRIEF.md
# Rolling-Code Receiver Validator

This block sits on the receive side of a remote keyless entry link in which every button press produces a new 32-bit encrypted word. Each received frame has a serial number and button bits sent in the clear, plus the encrypted hop word. The block first compares the clear serial number with the learned one. If they match, it decrypts the hop word with the learned 64-bit device key. The cipher is a 32-bit nonlinear feedback shift register run for 528 rounds, one round per clock. From the recovered plaintext the block checks the fixed padding fields. It then checks that the 16-bit press counter has moved forward by a small, bounded amount since the last frame it accepted.

The learned serial number, device key, overflow bits and starting counter are supplied from outside, because the learning procedure is not part of this block. The learned starting counter is written through a load strobe. Every frame produces exactly one result pulse: either accept, or reject with a 2-bit reason. Only an accepted frame moves the stored counter forward. While a decryption is in progress, the block ignores any new frame.

Top module: `rc_rx_validator`

## Requirements
- R1: After reset, `busy_o`, `res_valid_o`, `accept_o` and `reject_o` are low and the stored counter is 0, so a first frame with counter 1 is accepted.
- R2: A frame whose clear serial differs from `lrn_serial_i` is rejected with reason 2'b01 one cycle after it is taken, without starting a decryption (`busy_o` stays low).
- R3: The hop word is decrypted with 528 rounds. In round j, the new low bit is s[31]^s[15]^key[(15-j) mod 64]^T[{s[30],s[25],s[19],s[8],s[0]}], with T = 32'h3A5C742E, and the state shifts left. A correctly encrypted frame yields its plaintext.
- R4: The plaintext layout is: counter at bits 15:0, discrimination at bits 25:16, overflow at bits 27:26, button at bits 31:28. If the discrimination field differs from bits 9:0 of the learned serial, the frame is rejected with reason 2'b10.
- R5: If the decrypted button field differs from the clear button bits, or the overflow field differs from `lrn_ovf_i`, the frame is rejected with reason 2'b10.
- R6: With d = (counter - stored) mod 2^16, a frame is accepted when 1 <= d <= W. W is 16 when `win_wide_i` = 0 and 32 when it is 1. A larger d gives reason 2'b11.
- R7: A replay (d = 0) or a backward counter is rejected with reason 2'b11.
- R8: The window test wraps modulo 2^16: stored 16'hFFF8 with received 16'h0005 is accepted.
- R9: The stored counter takes the received counter only on accept. Rejected frames leave it unchanged.
- R10: A frame presented while `busy_o` is high is ignored and produces no result.
- R11: `cnt_load_i` writes `cnt_load_val_i` into the stored counter.
- R12: Every result pulse has exactly one of accept or reject high, and an accept carries reason 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_i | input | 64 | Learned device key |
| lrn_serial_i | input | 28 | Learned serial number |
| lrn_ovf_i | input | 2 | Expected overflow bits |
| win_wide_i | input | 1 | 0: window 16, 1: window 32 |
| cnt_load_i | input | 1 | Write the learned counter |
| cnt_load_val_i | input | 16 | Learned counter value |
| frm_valid_i | input | 1 | Frame present this cycle |
| frm_serial_i | input | 28 | Clear serial number of the frame |
| frm_button_i | input | 4 | Clear button bits of the frame |
| frm_hop_i | input | 32 | Encrypted hop word |
| busy_o | output | 1 | Decryption in progress |
| res_valid_o | output | 1 | One-cycle result pulse |
| accept_o | output | 1 | Frame accepted |
| reject_o | output | 1 | Frame rejected |
| reason_o | output | 2 | 00 accept, 01 serial, 10 padding, 11 counter window |

## Verification
Two situations are hard to reach from the ports. The first is the 16-bit counter wrap, which would take thousands of accepted frames to reach by counting. The bench reaches it by loading a learned counter just below 16'hFFFF and then sending a small counter value. The second is a frame arriving during a 528-cycle decryption. The bench injects a second, fully valid frame a few cycles after the first. It then shows that this frame was dropped in two ways: no extra result pulse appears, and a later copy of it is still accepted instead of being rejected as a replay.

// File: rtl/rc_pkg.sv
package rc_pkg;
    localparam int BLK_W   = 32;
    localparam int KEY_W   = 64;
    localparam int ROUNDS  = 528;
    localparam int CNT_W   = 16;
    localparam int SER_W   = 28;
    localparam int DISC_W  = 10;
    localparam int BTN_W   = 4;
    localparam int OVF_W   = 2;
    localparam logic [31:0] NLF_TABLE = 32'h3A5C742E;

    typedef enum logic [1:0] {
        RSN_NONE   = 2'b00,
        RSN_SERIAL = 2'b01,
        RSN_PAD    = 2'b10,
        RSN_WINDOW = 2'b11
    } reason_e;

    typedef struct packed {
        logic [BTN_W-1:0]  btn;
        logic [OVF_W-1:0]  ovf;
        logic [DISC_W-1:0] disc;
        logic [CNT_W-1:0]  cnt;
    } plain_t;

    typedef struct packed {
        logic    accept;
        reason_e reason;
    } verdict_t;

    function automatic logic nlf(input logic [4:0] sel);
        return NLF_TABLE[sel];
    endfunction

    function automatic logic [BLK_W-1:0] dec_round(input logic [BLK_W-1:0] s, input logic kbit);
        logic fb;
        fb = s[31] ^ s[15] ^ kbit ^ nlf({s[30], s[25], s[19], s[8], s[0]});
        return {s[BLK_W-2:0], fb};
    endfunction
endpackage

// File: rtl/rc_dec_core.sv
module rc_dec_core
    import rc_pkg::*;
#(
    parameter int N_ROUNDS = ROUNDS,
    parameter int K_W      = KEY_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [K_W-1:0]   key,
    input  logic [BLK_W-1:0] blk_in,
    output logic             done,
    output logic [BLK_W-1:0] blk_out
);
    localparam int RND_W   = $clog2(N_ROUNDS);
    localparam int KIDX_W  = $clog2(K_W);
    localparam int KEY_OFS = (N_ROUNDS - 1) % K_W;

    logic              run;
    logic [RND_W-1:0]  rnd;
    logic [BLK_W-1:0]  st;
    logic [KIDX_W-1:0] kidx;

    assign kidx    = KIDX_W'(KEY_OFS) - rnd[KIDX_W-1:0];
    assign blk_out = st;

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= 1'b0;
            done <= 1'b0;
            rnd  <= '0;
            st   <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                st  <= blk_in;
                rnd <= '0;
                run <= 1'b1;
            end else if (run) begin
                st <= dec_round(st, key[kidx]);
                if (rnd == RND_W'(N_ROUNDS - 1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end else begin
                    rnd <= rnd + 1'b1;
                end
            end
        end
    end

    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(run)); // R3
    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        start |-> !run); // R10
    AST_RND_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        run |-> (rnd < RND_W'(N_ROUNDS))); // R3
endmodule

// File: rtl/rc_frame_judge.sv
module rc_frame_judge
    import rc_pkg::*;
#(
    parameter int WIN_NARROW = 16,
    parameter int WIN_WIDE   = 32
) (
    input  plain_t            plain,
    input  logic [DISC_W-1:0] exp_disc,
    input  logic [BTN_W-1:0]  clr_btn,
    input  logic [OVF_W-1:0]  exp_ovf,
    input  logic [CNT_W-1:0]  last_cnt,
    input  logic              win_wide,
    output verdict_t          verdict
);
    logic [CNT_W-1:0] diff;
    logic [CNT_W-1:0] win;
    logic             pad_ok;
    logic             in_win;

    always_comb begin
        diff   = plain.cnt - last_cnt;
        win    = win_wide ? CNT_W'(WIN_WIDE) : CNT_W'(WIN_NARROW);
        pad_ok = (plain.disc == exp_disc) && (plain.btn == clr_btn) && (plain.ovf == exp_ovf);
        in_win = (diff != '0) && (diff <= win);
        if (!pad_ok) begin
            verdict = '{accept: 1'b0, reason: RSN_PAD};
        end else if (!in_win) begin
            verdict = '{accept: 1'b0, reason: RSN_WINDOW};
        end else begin
            verdict = '{accept: 1'b1, reason: RSN_NONE};
        end
    end
endmodule

// File: rtl/rc_ctr_keeper.sv
module rc_ctr_keeper
    import rc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             upd,
    input  logic [CNT_W-1:0] upd_val,
    output logic [CNT_W-1:0] last
);
    always_ff @(posedge clk) begin
        if (rst) begin
            last <= '0;
        end else if (load) begin
            last <= load_val;
        end else if (upd) begin
            last <= upd_val;
        end
    end

    AST_CTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && !upd) |=> $stable(last)); // R9
endmodule

// File: rtl/rc_rx_validator.sv
module rc_rx_validator
    import rc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [KEY_W-1:0]  key_i,
    input  logic [SER_W-1:0]  lrn_serial_i,
    input  logic [OVF_W-1:0]  lrn_ovf_i,
    input  logic              win_wide_i,
    input  logic              cnt_load_i,
    input  logic [CNT_W-1:0]  cnt_load_val_i,
    input  logic              frm_valid_i,
    input  logic [SER_W-1:0]  frm_serial_i,
    input  logic [BTN_W-1:0]  frm_button_i,
    input  logic [BLK_W-1:0]  frm_hop_i,
    output logic              busy_o,
    output logic              res_valid_o,
    output logic              accept_o,
    output logic              reject_o,
    output logic [1:0]        reason_o
);
    typedef enum logic {S_IDLE, S_DEC} state_e;

    state_e           state;
    logic [BTN_W-1:0] btn_q;
    logic             take;
    logic             ser_ok;
    logic             start;
    logic             core_done;
    logic [BLK_W-1:0] core_out;
    plain_t           core_plain;
    verdict_t         verdict;
    logic [CNT_W-1:0] last_cnt;
    logic             upd;

    assign take       = (state == S_IDLE) && frm_valid_i;
    assign ser_ok     = (frm_serial_i == lrn_serial_i);
    assign start      = take && ser_ok;
    assign core_plain = plain_t'(core_out);
    assign upd        = (state == S_DEC) && core_done && verdict.accept;
    assign busy_o     = (state == S_DEC);

    rc_dec_core u_core (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .key     (key_i),
        .blk_in  (frm_hop_i),
        .done    (core_done),
        .blk_out (core_out)
    );

    rc_frame_judge u_judge (
        .plain    (core_plain),
        .exp_disc (lrn_serial_i[DISC_W-1:0]),
        .clr_btn  (btn_q),
        .exp_ovf  (lrn_ovf_i),
        .last_cnt (last_cnt),
        .win_wide (win_wide_i),
        .verdict  (verdict)
    );

    rc_ctr_keeper u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load_i),
        .load_val (cnt_load_val_i),
        .upd      (upd),
        .upd_val  (core_plain.cnt),
        .last     (last_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            btn_q       <= '0;
            res_valid_o <= 1'b0;
            accept_o    <= 1'b0;
            reject_o    <= 1'b0;
            reason_o    <= RSN_NONE;
        end else begin
            res_valid_o <= 1'b0;
            accept_o    <= 1'b0;
            reject_o    <= 1'b0;
            reason_o    <= RSN_NONE;
            case (state)
                S_IDLE: begin
                    if (take) begin
                        btn_q <= frm_button_i;
                        if (ser_ok) begin
                            state <= S_DEC;
                        end else begin
                            res_valid_o <= 1'b1;
                            reject_o    <= 1'b1;
                            reason_o    <= RSN_SERIAL;
                        end
                    end
                end
                S_DEC: begin
                    if (core_done) begin
                        res_valid_o <= 1'b1;
                        accept_o    <= verdict.accept;
                        reject_o    <= !verdict.accept;
                        reason_o    <= verdict.reason;
                        state       <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> (accept_o ^ reject_o)); // R12
    AST_ACCEPT_REASON: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> (reason_o == RSN_NONE)); // R12
    AST_SERIAL_FIRST: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && frm_valid_i && (frm_serial_i != lrn_serial_i))
        |=> (reject_o && reason_o == RSN_SERIAL && !busy_o)); // R2
    AST_ACCEPT_STORES: assert property (@(posedge clk) disable iff (rst)
        (accept_o && !$past(cnt_load_i)) |-> (last_cnt == core_plain.cnt)); // R9
    AST_RESULT_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && !$past(busy_o)) |-> $past(frm_valid_i)); // R10
endmodule

// File: tb/rc_rx_validator_bench.sv
module rc_rx_validator_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] key_i = 64'h5CEC6701B79FD949;
    logic [27:0] lrn_serial_i = 28'h5A3C1E7;
    logic [1:0]  lrn_ovf_i = 2'b00;
    logic        win_wide_i = 1'b0;
    logic        cnt_load_i = 1'b0;
    logic [15:0] cnt_load_val_i = '0;
    logic        frm_valid_i = 1'b0;
    logic [27:0] frm_serial_i = '0;
    logic [3:0]  frm_button_i = '0;
    logic [31:0] frm_hop_i = '0;
    logic        busy_o, res_valid_o, accept_o, reject_o;
    logic [1:0]  reason_o;

    int n_tests = 0;
    int n_fail  = 0;
    localparam logic [3:0] BTN = 4'h2;

    always #5 clk = ~clk;

    rc_rx_validator u_rc_rx_validator (.*);

    function automatic logic [31:0] encrypt(logic [31:0] p, logic [63:0] k);
        logic [31:0] y;
        logic [31:0] t;
        logic b;
        t = 32'h3A5C742E;
        y = p;
        for (int i = 0; i < 528; i++) begin
            b = y[0] ^ y[16] ^ k[i % 64] ^ t[{y[31], y[26], y[20], y[9], y[1]}];
            y = {b, y[31:1]};
        end
        return y;
    endfunction

    function automatic logic [31:0] mk_plain(logic [3:0] b, logic [1:0] o, logic [9:0] d, logic [15:0] c);
        return {b, o, d, c};
    endfunction

    task automatic check(string tag, logic cond, string what, int act, int exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic run_frame(string tag, logic [27:0] ser, logic [3:0] cbtn, logic [31:0] pt,
                             logic exp_acc, logic [1:0] exp_rsn);
        bit seen = 0;
        @(negedge clk);
        frm_valid_i  = 1'b1;
        frm_serial_i = ser;
        frm_button_i = cbtn;
        frm_hop_i    = encrypt(pt, key_i);
        @(negedge clk);
        frm_valid_i = 1'b0;
        for (int i = 0; i < 1000 && !seen; i++) begin
            if (res_valid_o) seen = 1;
            else @(negedge clk);
        end
        check(tag, seen, "result pulse", seen, 1);
        if (seen) begin
            check(tag, accept_o == exp_acc && reject_o == !exp_acc, "accept", accept_o, exp_acc);
            check(tag, reason_o == exp_rsn, "reason", reason_o, exp_rsn);
        end
    endtask

    task automatic good(string tag, logic [15:0] c, logic acc, logic [1:0] rsn);
        run_frame(tag, lrn_serial_i, BTN, mk_plain(BTN, 2'b00, lrn_serial_i[9:0], c), acc, rsn);
    endtask

    task automatic t_reset();
        check("R1", !busy_o && !res_valid_o && !accept_o && !reject_o, "idle outputs",
              {busy_o, res_valid_o, accept_o, reject_o}, 0);
        good("R1_R3", 16'd1, 1'b1, 2'b00);
    endtask

    task automatic t_window();
        good("R6", 16'd17, 1'b1, 2'b00);
        good("R6", 16'd34, 1'b0, 2'b11);
        win_wide_i = 1'b1;
        good("R6", 16'd49, 1'b1, 2'b00);
        good("R6", 16'd82, 1'b0, 2'b11);
        win_wide_i = 1'b0;
    endtask

    task automatic t_replay();
        good("R7", 16'd49, 1'b0, 2'b11);
        good("R7", 16'd40, 1'b0, 2'b11);
        good("R9", 16'd50, 1'b1, 2'b00);
    endtask

    task automatic t_serial();
        run_frame("R2", lrn_serial_i ^ 28'h0000100, BTN,
                  mk_plain(BTN, 2'b00, lrn_serial_i[9:0], 16'd51), 1'b0, 2'b01);
        check("R2", !busy_o, "busy after serial reject", busy_o, 0);
        good("R9", 16'd51, 1'b1, 2'b00);
    endtask

    task automatic t_padding();
        run_frame("R4", lrn_serial_i, BTN,
                  mk_plain(BTN, 2'b00, lrn_serial_i[9:0] ^ 10'h001, 16'd52), 1'b0, 2'b10);
        run_frame("R5", lrn_serial_i, 4'h4,
                  mk_plain(BTN, 2'b00, lrn_serial_i[9:0], 16'd52), 1'b0, 2'b10);
        run_frame("R5", lrn_serial_i, BTN,
                  mk_plain(BTN, 2'b01, lrn_serial_i[9:0], 16'd52), 1'b0, 2'b10);
        good("R9", 16'd52, 1'b1, 2'b00);
    endtask

    task automatic t_wrap();
        @(negedge clk);
        cnt_load_i     = 1'b1;
        cnt_load_val_i = 16'hFFF8;
        @(negedge clk);
        cnt_load_i = 1'b0;
        good("R11", 16'hFFF7, 1'b0, 2'b11);
        good("R8", 16'h0005, 1'b1, 2'b00);
    endtask

    task automatic t_busy_drop();
        int extra = 0;
        @(negedge clk);
        frm_valid_i  = 1'b1;
        frm_serial_i = lrn_serial_i;
        frm_button_i = BTN;
        frm_hop_i    = encrypt(mk_plain(BTN, 2'b00, lrn_serial_i[9:0], 16'h0006), key_i);
        @(negedge clk);
        frm_valid_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R10", busy_o, "busy during decrypt", busy_o, 1);
        frm_valid_i = 1'b1;
        frm_hop_i   = encrypt(mk_plain(BTN, 2'b00, lrn_serial_i[9:0], 16'h0007), key_i);
        @(negedge clk);
        frm_valid_i = 1'b0;
        while (!res_valid_o) @(negedge clk);
        check("R10", accept_o, "first frame accept", accept_o, 1);
        for (int i = 0; i < 700; i++) begin
            @(negedge clk);
            if (res_valid_o) extra++;
        end
        check("R10", extra == 0, "extra results", extra, 0);
        good("R10", 16'h0007, 1'b1, 2'b00);
    endtask

    initial begin
        #(1_500_000);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_window();
        t_replay();
        t_serial();
        t_padding();
        t_wrap();
        t_busy_drop();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule